// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block decides which interrupt a small 8-bit processor core takes next. It has two kinds of source. Event sources set a sticky flag that stays set until the core vectors to that source or software clears it. Level sources have no flag and ask for service only while their input is high. Each source has its own enable bit. A single global enable gates every request. The block gets strobes from the core when an instruction retires and when a return-from-interrupt executes.

The core takes an interrupt in the cycle where `takeReq` is high and jumps to the entry selected by `takeIdx`. Event sources use indices 0 to NUM_EVT-1. Level sources follow them, starting at NUM_EVT. The block clears the taken event flag and the global enable by itself. Software reads the flags on `flagRd` and clears them by writing ones. The core's status word and context saving stay outside the block, and the block never touches them.

Top module: `intFlagCtrl`

## Requirements
- R1: After reset, every event flag reads 0, the global enable `gieOut` is 0, and `takeReq` is 0.
- R2: A high `evtIn[i]` sets flag i on the next clock edge. The flag stays set while source i or the global enable is off, and no request is raised during that time.
- R3: `takeReq` is combinational. It is high in a cycle when the global enable is on, no post-return block is active, and at least one enabled request is pending. `takeIdx` then names the lowest-numbered enabled pending source. Event source i is index i, and level input j is index NUM_EVT+j.
- R4: When an event source is taken, its flag is 0 after the next edge. All other flags keep their value.
- R5: A new event wins on the same source in the same cycle. If `evtIn[i]` arrives together with a vectoring clear or a software clear of flag i, flag i ends up set.
- R6: When `flagWrEn` is high, each one in `flagWrData` clears the matching flag on the next edge. Zero bits leave their flags unchanged.
- R7: A level source requests only while its input is high and its enable bit is set. If the input falls before the source is enabled, no request follows.
- R8: Taking an interrupt sets `gieOut` to 0 on the next edge. A `gieSet` pulse or a `retiStb` pulse sets it to 1 on the next edge.
- R9: When `gieClr` is high, `takeReq` is 0 in that same cycle, and `gieOut` is 0 after the edge. A flag whose take was refused stays set.
- R10: After a `retiStb` pulse, `takeReq` stays 0 until a `retireStb` pulse has been seen in an earlier cycle. The earliest possible take is the cycle after that retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | NUM_EVT | Event source inputs; a high cycle sets the flag |
| lvlIn | input | NUM_LVL | Level source conditions |
| srcEn | input | NUM_EVT+NUM_LVL | Per-source enables, event sources first |
| gieSet | input | 1 | Software sets the global enable |
| gieClr | input | 1 | Software clears the global enable, effective in the same cycle |
| retireStb | input | 1 | One main-program instruction retired |
| retiStb | input | 1 | Return-from-interrupt executed |
| flagWrEn | input | 1 | Flag write strobe |
| flagWrData | input | NUM_EVT | Write-one-to-clear data |
| flagRd | output | NUM_EVT | Current event flags |
| gieOut | output | 1 | Current global enable |
| takeReq | output | 1 | Take an interrupt this cycle |
| takeIdx | output | clog2(NUM_EVT+NUM_LVL) | Index of the winning source |

## Verification
Two of this block's functions can fall in the same cycle on the same source. One is the flag clear that the block performs when it vectors to an event source. The other is a fresh event on that source. The bench provokes this by raising `evtIn` in the same cycle where `takeReq` is high for that source, and it repeats the test with a software write-one-to-clear in place of the vectoring clear. It judges the result by the flag read back after the edge, which must still be set, together with a correct drop of the global enable. A second collision pairs `gieClr` with a live request: the bench checks that no take appears in that cycle and that the refused flag survives.

// File: rtl/intPkg.sv
package intPkg;

  // Strobes that the control half hands to the datapath each cycle
  typedef struct packed {
    logic fire;      // interrupt taken this cycle
    logic gieDrop;   // global enable goes low
    logic gieRaise;  // global enable goes high
    logic guardSet;  // return seen: block takes until a retire
    logic guardClr;  // main-program instruction retired
  } ctlStrobes_t;

endpackage

// File: rtl/intCtl.sv
module intCtl
  import intPkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int NUM_LVL = 2,
  localparam int NUM_SRC = NUM_EVT + NUM_LVL,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] flagQ,
  input  logic [NUM_LVL-1:0] lvlIn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               gieQ,
  input  logic               guardQ,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic               retireStb,
  input  logic               retiStb,
  output ctlStrobes_t        strb,
  output logic [IDX_W-1:0]   takeIdx
);

  logic [NUM_SRC-1:0] reqVec;
  logic               pendAny;

  // Request vector: sticky flags first, then live level conditions
  genvar gi;
  generate
    for (gi = 0; gi < NUM_EVT; gi++) begin : g_evtReq
      assign reqVec[gi] = flagQ[gi] & srcEn[gi];
    end
    for (gi = 0; gi < NUM_LVL; gi++) begin : g_lvlReq
      assign reqVec[NUM_EVT+gi] = lvlIn[gi] & srcEn[NUM_EVT+gi];
    end
  endgenerate

  // Fixed priority: lowest index wins
  always_comb begin
    pendAny = 1'b0;
    takeIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        pendAny = 1'b1;
        takeIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strb.fire     = pendAny & gieQ & ~guardQ & ~gieClr & ~retiStb;
    strb.gieDrop  = strb.fire | gieClr;
    strb.gieRaise = gieSet | retiStb;
    strb.guardSet = retiStb;
    strb.guardClr = retireStb & ~retiStb;
  end

  AST_FIRE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> gieQ) else $error("fire without global enable"); // R8
  AST_NO_FIRE_ON_CLR: assert property (@(posedge clk) disable iff (!rstN)
    gieClr |-> !strb.fire) else $error("fire during global clear"); // R9
  AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    guardQ |-> !strb.fire) else $error("fire before retire after return"); // R10
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> (((reqVec >> takeIdx) & NUM_SRC'(1)) != '0)) else $error("winner not pending"); // R3
  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> ((reqVec & ((NUM_SRC'(1) << takeIdx) - NUM_SRC'(1))) == '0)) else $error("higher priority skipped"); // R3

endmodule

// File: rtl/intDp.sv
module intDp
  import intPkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int NUM_LVL = 2,
  localparam int NUM_SRC = NUM_EVT + NUM_LVL,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               flagWrEn,
  input  logic [NUM_EVT-1:0] flagWrData,
  input  ctlStrobes_t        strb,
  input  logic [IDX_W-1:0]   takeIdx,
  output logic [NUM_EVT-1:0] flagQ,
  output logic               gieQ,
  output logic               guardQ
);

  logic [NUM_EVT-1:0] hwClr;
  logic [NUM_EVT-1:0] swClr;
  logic [NUM_EVT-1:0] flagD;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EVT; gi++) begin : g_hwClr
      assign hwClr[gi] = strb.fire & (takeIdx == IDX_W'(gi));
    end
  endgenerate

  assign swClr = flagWrEn ? flagWrData : '0;
  // New events override both kinds of clear
  assign flagD = (flagQ & ~hwClr & ~swClr) | evtIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ  <= '0;
      gieQ   <= 1'b0;
      guardQ <= 1'b0;
    end else begin
      flagQ <= flagD;
      if (strb.gieDrop)       gieQ <= 1'b0;
      else if (strb.gieRaise) gieQ <= 1'b1;
      if (strb.guardSet)      guardQ <= 1'b1;
      else if (strb.guardClr) guardQ <= 1'b0;
    end
  end

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((flagQ & $past(evtIn)) == $past(evtIn))) else $error("event lost"); // R5
  AST_TAKE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((hwClr & ~evtIn) != '0) |=> ((flagQ & $past(hwClr & ~evtIn)) == '0)) else $error("taken flag kept"); // R4
  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> !gieQ) else $error("global enable kept after take"); // R8
  AST_GUARD_AFTER_RETI: assert property (@(posedge clk) disable iff (!rstN)
    strb.guardSet |=> guardQ) else $error("no guard after return"); // R10
  AST_HWCLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hwClr)) else $error("several flags cleared by one take"); // R4

endmodule

// File: rtl/intFlagCtrl.sv
module intFlagCtrl
  import intPkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int NUM_LVL = 2,
  localparam int NUM_SRC = NUM_EVT + NUM_LVL,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [NUM_LVL-1:0] lvlIn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic               retireStb,
  input  logic               retiStb,
  input  logic               flagWrEn,
  input  logic [NUM_EVT-1:0] flagWrData,
  output logic [NUM_EVT-1:0] flagRd,
  output logic               gieOut,
  output logic               takeReq,
  output logic [IDX_W-1:0]   takeIdx
);

  ctlStrobes_t        strb;
  logic [NUM_EVT-1:0] flagQ;
  logic               gieQ;
  logic               guardQ;

  intCtl #(.NUM_EVT(NUM_EVT), .NUM_LVL(NUM_LVL)) i_ctl (
    .clk(clk), .rstN(rstN), .flagQ(flagQ), .lvlIn(lvlIn), .srcEn(srcEn),
    .gieQ(gieQ), .guardQ(guardQ), .gieSet(gieSet), .gieClr(gieClr),
    .retireStb(retireStb), .retiStb(retiStb), .strb(strb), .takeIdx(takeIdx)
  );

  intDp #(.NUM_EVT(NUM_EVT), .NUM_LVL(NUM_LVL)) i_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .strb(strb), .takeIdx(takeIdx),
    .flagQ(flagQ), .gieQ(gieQ), .guardQ(guardQ)
  );

  assign flagRd  = flagQ;
  assign gieOut  = gieQ;
  assign takeReq = strb.fire;

endmodule

// File: tb/test_intFlagCtrl.sv
`timescale 1ns/1ps
module test_intFlagCtrl;

  localparam int NE = 4;
  localparam int NL = 2;
  localparam int NS = NE + NL;
  localparam int IW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rstN;
  logic [NE-1:0] evtIn;
  logic [NL-1:0] lvlIn;
  logic [NS-1:0] srcEn;
  logic          gieSet, gieClr, retireStb, retiStb, flagWrEn;
  logic [NE-1:0] flagWrData;
  logic [NE-1:0] flagRd;
  logic          gieOut, takeReq;
  logic [IW-1:0] takeIdx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intFlagCtrl #(.NUM_EVT(NE), .NUM_LVL(NL)) i_intFlagCtrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .lvlIn(lvlIn), .srcEn(srcEn),
    .gieSet(gieSet), .gieClr(gieClr), .retireStb(retireStb), .retiStb(retiStb),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .flagRd(flagRd),
    .gieOut(gieOut), .takeReq(takeReq), .takeIdx(takeIdx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance to the next low phase and settle
  task automatic nextLow();
    @(negedge clk);
    #0.5;
  endtask

  task automatic idleIns();
    evtIn = '0; lvlIn = '0; gieSet = 0; gieClr = 0;
    retireStb = 0; retiStb = 0; flagWrEn = 0; flagWrData = '0;
  endtask

  function automatic int lowest(input int m);
    for (int i = 0; i < NS; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idleIns();
    srcEn = '0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #0.5;
    chk("R1 flags", flagRd, 0);
    chk("R1 gie", gieOut, 0);
    chk("R1 take", takeReq, 0);

    // Sweep every pending pattern against every enable pattern
    for (int p = 0; p < (1 << NS); p++) begin
      for (int e = 0; e < (1 << NS); e++) begin
        int win;
        @(negedge clk);
        srcEn = NS'(e); evtIn = NE'(p); lvlIn = NL'(p >> NE);
        #0.5;
        chk("R2 no take while global off", takeReq, 0);
        @(negedge clk);
        evtIn = '0; gieSet = 1;
        #0.5;
        chk("R2 flags latched", flagRd, p & ((1 << NE) - 1));
        chk("R2 no take while global off", takeReq, 0);
        @(negedge clk);
        gieSet = 0;
        #0.5;
        win = lowest(p & e);
        chk("R3 take", takeReq, (win >= 0) ? 1 : 0);
        if (win >= 0) chk("R3 index", takeIdx, win);
        @(negedge clk);
        #0.5;
        if (win >= 0) begin
          chk("R8 gie dropped", gieOut, 0);
          chk("R4 flags", flagRd,
              (p & ((1 << NE) - 1)) & ~((win < NE) ? (1 << win) : 0));
        end else begin
          chk("R8 gie raised", gieOut, 1);
          chk("R2 flags unchanged", flagRd, p & ((1 << NE) - 1));
        end
        gieClr = 1; lvlIn = '0; flagWrEn = 1; flagWrData = '1;
        @(negedge clk);
        idleIns();
        #0.5;
        chk("R6 cleared by ones", flagRd, 0);
        chk("R9 gie off", gieOut, 0);
      end
    end

    // R5: event and vectoring clear on the same source, same cycle
    srcEn = '1;
    @(negedge clk); evtIn = 4'b0100;
    @(negedge clk); evtIn = '0; gieSet = 1;
    nextLow(); gieSet = 0;
    chk("R3 single source", takeIdx, 2);
    chk("R3 take", takeReq, 1);
    evtIn = 4'b0100;
    nextLow(); evtIn = '0;
    chk("R5 event beats vector clear", flagRd, 4'b0100);
    chk("R8 gie dropped", gieOut, 0);
    // R5: event and software clear together
    flagWrEn = 1; flagWrData = 4'b0100; evtIn = 4'b0100;
    nextLow(); idleIns();
    chk("R5 event beats sw clear", flagRd, 4'b0100);
    // R6: zeros written change nothing
    flagWrEn = 1; flagWrData = 4'b1011;
    nextLow(); idleIns();
    chk("R6 zero bits no effect", flagRd, 4'b0100);
    flagWrEn = 1; flagWrData = 4'b0100;
    nextLow(); idleIns();
    chk("R6 one clears", flagRd, 0);

    // R7: level condition gone before enable leaves nothing
    srcEn = '1; srcEn[NE] = 0;
    gieSet = 1;
    nextLow(); gieSet = 0;
    lvlIn = 2'b01;
    #0.5;
    chk("R7 disabled level", takeReq, 0);
    nextLow(); lvlIn = '0;
    nextLow(); srcEn = '1;
    #0.5;
    chk("R7 no memory", takeReq, 0);
    nextLow(); lvlIn = 2'b01;
    #0.5;
    chk("R7 live level take", takeReq, 1);
    chk("R7 level index", takeIdx, NE);
    nextLow(); lvlIn = '0;
    chk("R8 gie dropped", gieOut, 0);
    chk("R7 no flag", flagRd, 0);

    // R9: global clear in the same cycle as a request
    evtIn = 4'b0010;
    nextLow(); evtIn = '0; gieSet = 1;
    nextLow(); gieSet = 0;
    chk("R9 request present", takeReq, 1);
    gieClr = 1;
    #0.5;
    chk("R9 no take with clear", takeReq, 0);
    nextLow(); gieClr = 0;
    chk("R9 gie off", gieOut, 0);
    chk("R9 flag kept", flagRd, 4'b0010);

    // R10: return then wait for one retire
    retiStb = 1;
    #0.5;
    chk("R10 no take at return", takeReq, 0);
    nextLow(); retiStb = 0;
    chk("R8 gie raised by return", gieOut, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R10 blocked before retire", takeReq, 0);
      nextLow();
    end
    retireStb = 1;
    #0.5;
    chk("R10 blocked in retire cycle", takeReq, 0);
    nextLow(); retireStb = 0;
    chk("R10 take after retire", takeReq, 1);
    chk("R10 index", takeIdx, 1);
    nextLow();
    chk("R4 flag cleared", flagRd, 0);
    chk("R8 gie dropped", gieOut, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule